// File: doc/BRIEF.md
# Configurable-Sense Interrupt Controller Bank

A bank of 32 interrupt request lines, each of which can be programmed to detect either an edge or a level and to treat either the high or the low sense as active. Every line passes through a two-flop synchronizer. The resulting pending state sits in a status register.

In edge mode a qualifying edge sets a sticky status bit, and software clears that bit by writing a one to it. In level mode the status bit simply follows the active level. A per-line enable register masks pending lines off the outputs. A per-line fast-select register steers enabled pending lines to the fast request output instead of the normal request output.

Four line positions are reserved for cascading two subordinate banks. Lines 0 and 1 take the normal requests of subordinate banks 0 and 1. Lines 30 and 31 take their fast requests. The remaining 28 lines come from the general request port. Software reaches the bank through a plain register port: a write strobe, an address, write data and combinational read data.

Top module: `sense_intc`

## Requirements
- R1: After reset the enable, type and fast-select registers read 0, the polarity register reads all ones (level sensing, active-high), and both request outputs are low.
- R2: `irq_out` is high only when some line has both its pending bit and its enable bit set (enable register, address 0) and is not fast-selected. A cleared enable bit keeps that line off both outputs.
- R3: A write to the status register (address 1) clears every edge-mode status bit whose written bit is 1. Status bits whose written bit is 0 keep their value.
- R4: With type bit 1 (edge, address 2) and polarity bit 1 (address 3), a rising edge sets the status bit. The bit stays set after the input returns low, until it is cleared.
- R5: With type bit 1 and polarity bit 0, a falling edge sets the status bit.
- R6: With type bit 0 (level), the status bit equals the input when the polarity bit is 1 and the inverted input when it is 0. A write of 1 to clear the bit has no lasting effect while the level stays active.
- R7: No setting detects both edges. An edge line configured for one direction never latches on the opposite edge.
- R8: Status bits 0 and 1 follow `sub_irq[0]` and `sub_irq[1]`. Bits 30 and 31 follow `sub_fiq[0]` and `sub_fiq[1]`. Bit k of `line_in` drives line k+2, for k from 0 to 27.
- R9: An enabled pending line whose fast-select bit (address 4) is 1 drives `fiq_out` and not `irq_out`.
- R10: An input change reaches the status register on the third rising clock edge after it is applied, and not on the second.
- R11: Reads return the enable, status, type, polarity and fast-select registers at addresses 0 to 4. Every other address reads 0.
- R12: The mask-and-acknowledge sequence works as follows. Clearing the enable bit first, and then writing a one to the status bit, leaves the line quiet, and the line stays quiet when it is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 28 | General request lines, bit k drives line k+2 |
| sub_irq | input | 2 | Normal requests of subordinate banks 0 and 1 (lines 0, 1) |
| sub_fiq | input | 2 | Fast requests of subordinate banks 0 and 1 (lines 30, 31) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The bench applies single pulses, held levels and level changes to lines configured in each of the four type and polarity combinations. This tells sticky edge latching apart from level following, and rising detection apart from falling detection. Pulses that return to idle before the status is read show whether edge status is truly sticky. An edge in the direction opposite to the configured one shows that no both-edge detection leaks through. The cascade inputs are driven one at a time while the general lines at the same positions stay high, which separates the subordinate routing from the general port. Clear writes with patterns of zeros and ones, together with changes to the enable and fast-select registers, separate masking, write-one-to-clear and output routing from one another.

// File: rtl/sense_intc_pkg.sv
package sense_intc_pkg;
  // Register addresses of the bank
  localparam int unsigned SEL_ENABLE   = 0;
  localparam int unsigned SEL_STATUS   = 1;
  localparam int unsigned SEL_TYPE     = 2;
  localparam int unsigned SEL_POLARITY = 3;
  localparam int unsigned SEL_FAST     = 4;
endpackage

// File: rtl/sense_intc_sync.sv
module sense_intc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_now,
  output logic [W-1:0] sync_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q    <= '0;
      sync_now  <= '0;
      sync_prev <= '0;
    end else begin
      meta_q    <= raw_in;
      sync_now  <= meta_q;
      sync_prev <= sync_now;
    end
  end
endmodule

// File: rtl/sense_intc_detect.sv
module sense_intc_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_now,
  input  logic [W-1:0] sync_prev,
  input  logic [W-1:0] type_edge,
  input  logic [W-1:0] pol_high,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] pend_q
);
  // Exactly one edge direction per line: the polarity picks it.
  function automatic logic [W-1:0] f_edge(input logic [W-1:0] s,
                                           input logic [W-1:0] d,
                                           input logic [W-1:0] pol);
    return (pol & s & ~d) | (~pol & ~s & d);
  endfunction

  function automatic logic [W-1:0] f_active(input logic [W-1:0] s,
                                             input logic [W-1:0] pol);
    return ~(s ^ pol);
  endfunction

  logic [W-1:0] level_act;
  logic [W-1:0] pend_d;

  assign edge_hit  = type_edge & f_edge(sync_now, sync_prev, pol_high);
  assign level_act = f_active(sync_now, pol_high);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_line
      always_comb begin
        if (type_edge[i]) pend_d[i] = (pend_q[i] & ~clr_mask[i]) | edge_hit[i];
        else              pend_d[i] = level_act[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/sense_intc_regs.sv
module sense_intc_regs
  import sense_intc_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pend_q,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      type_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      fast_q,
  output logic [W-1:0]      clr_mask,
  output logic [W-1:0]      rdata
);
  logic hit_en, hit_st, hit_ty, hit_po, hit_fa;

  assign hit_en = wr_en && (addr == ADDR_W'(SEL_ENABLE));
  assign hit_st = wr_en && (addr == ADDR_W'(SEL_STATUS));
  assign hit_ty = wr_en && (addr == ADDR_W'(SEL_TYPE));
  assign hit_po = wr_en && (addr == ADDR_W'(SEL_POLARITY));
  assign hit_fa = wr_en && (addr == ADDR_W'(SEL_FAST));

  assign clr_mask = hit_st ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      type_q <= '0;
      pol_q  <= '1;
      fast_q <= '0;
    end else begin
      if (hit_en) en_q   <= wdata;
      if (hit_ty) type_q <= wdata;
      if (hit_po) pol_q  <= wdata;
      if (hit_fa) fast_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(SEL_ENABLE):   rdata = en_q;
      ADDR_W'(SEL_STATUS):   rdata = pend_q;
      ADDR_W'(SEL_TYPE):     rdata = type_q;
      ADDR_W'(SEL_POLARITY): rdata = pol_q;
      ADDR_W'(SEL_FAST):     rdata = fast_q;
      default:               rdata = '0;
    endcase
  end
endmodule

// File: rtl/sense_intc.sv
module sense_intc #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned GEN_W     = NUM_LINES - 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GEN_W-1:0]     line_in,
  input  logic [1:0]           sub_irq,
  input  logic [1:0]           sub_fiq,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] rdata,
  output logic                 irq_out,
  output logic                 fiq_out
);
  localparam int unsigned CASC_FIQ0 = NUM_LINES - 2;

  function automatic logic f_route(input logic [NUM_LINES-1:0] p,
                                   input logic [NUM_LINES-1:0] e,
                                   input logic [NUM_LINES-1:0] sel);
    return |(p & e & sel);
  endfunction

  logic [NUM_LINES-1:0] merged_in;
  logic [NUM_LINES-1:0] sync_now, sync_prev;
  logic [NUM_LINES-1:0] edge_hit, pend_q, clr_mask;
  logic [NUM_LINES-1:0] en_q, type_q, pol_q, fast_q;

  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_merge
      if (i < 2) begin : g_sub_irq
        assign merged_in[i] = sub_irq[i];
      end else if (i >= CASC_FIQ0) begin : g_sub_fiq
        assign merged_in[i] = sub_fiq[i - CASC_FIQ0];
      end else begin : g_gen
        assign merged_in[i] = line_in[i - 2];
      end
    end
  endgenerate

  sense_intc_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(merged_in),
    .sync_now(sync_now), .sync_prev(sync_prev)
  );

  sense_intc_detect #(.W(NUM_LINES)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_now(sync_now), .sync_prev(sync_prev),
    .type_edge(type_q), .pol_high(pol_q), .clr_mask(clr_mask),
    .edge_hit(edge_hit), .pend_q(pend_q)
  );

  sense_intc_regs #(.W(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend_q(pend_q), .en_q(en_q), .type_q(type_q), .pol_q(pol_q),
    .fast_q(fast_q), .clr_mask(clr_mask), .rdata(rdata)
  );

  assign irq_out = f_route(pend_q, en_q, ~fast_q);
  assign fiq_out = f_route(pend_q, en_q, fast_q);
endmodule

// File: rtl/sense_intc_chk.sv
module sense_intc_chk
  import sense_intc_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      wdata,
  input logic [W-1:0]      pend,
  input logic [W-1:0]      en,
  input logic [W-1:0]      typ,
  input logic [W-1:0]      pol,
  input logic [W-1:0]      fast,
  input logic [W-1:0]      s_now,
  input logic [W-1:0]      s_prev,
  input logic [W-1:0]      edge_hit,
  input logic              irq_out,
  input logic              fiq_out
);
  logic st_wr;
  assign st_wr = wr_en && (addr == ADDR_W'(SEL_STATUS));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!irq_out && !fiq_out));

  assert_mask_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (!irq_out && !fiq_out));

  assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> ((pend & $past(wdata & typ & ~edge_hit)) == '0));

  assert_w1c_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> ((pend & $past(pend & typ & ~wdata)) == $past(pend & typ & ~wdata)));

  assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend ^ $past(~(s_now ^ pol))) & $past(~typ)) == '0));

  assert_edge_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & $past(typ) & ~$past(edge_hit)) == '0));

  assert_edge_needs_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit & ~(s_now ^ s_prev)) == '0);

  assert_fast_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en & fast) != '0) |-> fiq_out);

  assert_normal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en & ~fast) == '0) |-> !irq_out);
endmodule

bind sense_intc sense_intc_chk #(.W(NUM_LINES), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pend(pend_q), .en(en_q), .typ(type_q), .pol(pol_q), .fast(fast_q),
  .s_now(sync_now), .s_prev(sync_prev), .edge_hit(edge_hit),
  .irq_out(irq_out), .fiq_out(fiq_out)
);

// File: tb/sense_intc_tb_top.sv
`timescale 1ns/1ps
module sense_intc_tb_top;
  localparam logic [2:0] A_EN = 3'd0, A_ST = 3'd1, A_TY = 3'd2, A_PO = 3'd3, A_FA = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] line_in = '0;
  logic [1:0]  sub_irq = '0, sub_fiq = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out, fiq_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sense_intc dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .sub_irq(sub_irq),
    .sub_fiq(sub_fiq), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  function automatic logic [31:0] bitv(input int n);
    return 32'd1 << n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_in = '0; sub_irq = '0; sub_fiq = '0; wr_en = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(A_EN, v); chk("R1 enable after reset", v, 32'h0);
    rd(A_TY, v); chk("R1 type after reset", v, 32'h0);
    rd(A_PO, v); chk("R1 polarity after reset", v, 32'hFFFF_FFFF);
    rd(A_FA, v); chk("R1 fast select after reset", v, 32'h0);
    rd(A_ST, v); chk("R1 status after reset", v, 32'h0);
    chk("R1 outputs after reset", {30'd0, irq_out, fiq_out}, 32'h0);
    rd(3'd7, v); chk("R11 unmapped address", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    line_in[5-2] = 1'b1;
    wait_n(3);
    rd(A_ST, v); chk("R6 level high follows", v, bitv(5));
    chk("R2 masked line quiet", {31'd0, irq_out}, 32'h0);
    wr(A_EN, bitv(5));
    chk("R2 enabled line raises irq", {31'd0, irq_out}, 32'h1);
    rd(A_EN, v); chk("R11 enable readback", v, bitv(5));
    wr(A_ST, bitv(5));
    rd(A_ST, v); chk("R6 clear no lasting effect", v, bitv(5));
    line_in[5-2] = 1'b0;
    wait_n(3);
    rd(A_ST, v); chk("R6 level drop clears", v, 32'h0);
    chk("R2 irq drops with level", {31'd0, irq_out}, 32'h0);
    wr(A_PO, ~bitv(6));
    wait_n(1);
    rd(A_ST, v); chk("R6 active-low line low", v, bitv(6));
    line_in[6-2] = 1'b1;
    wait_n(3);
    rd(A_ST, v); chk("R6 active-low line high", v, 32'h0);
  endtask

  task automatic t_edge_rise();
    logic [31:0] v;
    do_reset();
    wr(A_TY, bitv(8) | bitv(10));
    line_in[8-2] = 1'b1;
    wait_n(2);
    rd(A_ST, v); chk("R10 not yet after two edges", v, 32'h0);
    wait_n(1);
    rd(A_ST, v); chk("R10 R4 latched on third edge", v, bitv(8));
    line_in[8-2] = 1'b0;
    wait_n(4);
    rd(A_ST, v); chk("R4 sticky after return", v, bitv(8));
    wr(A_ST, ~bitv(8));
    rd(A_ST, v); chk("R3 zero bit keeps status", v, bitv(8));
    wr(A_ST, bitv(8));
    rd(A_ST, v); chk("R3 one bit clears status", v, 32'h0);
    line_in[10-2] = 1'b1;
    wait_n(3);
    rd(A_ST, v); chk("R4 second rising line", v, bitv(10));
    wr(A_ST, bitv(10));
    line_in[10-2] = 1'b0;
    wait_n(4);
    rd(A_ST, v); chk("R7 rising line ignores fall", v, 32'h0);
  endtask

  task automatic t_edge_fall();
    logic [31:0] v;
    do_reset();
    line_in[9-2] = 1'b1;
    wait_n(4);
    wr(A_PO, ~bitv(9));
    wr(A_TY, bitv(9));
    wait_n(2);
    rd(A_ST, v); chk("R5 idle high no event", v, 32'h0);
    line_in[9-2] = 1'b0;
    wait_n(3);
    rd(A_ST, v); chk("R5 falling edge latched", v, bitv(9));
    wr(A_ST, bitv(9));
    line_in[9-2] = 1'b1;
    wait_n(4);
    rd(A_ST, v); chk("R7 falling line ignores rise", v, 32'h0);
  endtask

  task automatic t_fast();
    logic [31:0] v;
    do_reset();
    line_in[12-2] = 1'b1;
    wait_n(3);
    wr(A_EN, bitv(12));
    chk("R9 normal route", {30'd0, irq_out, fiq_out}, 32'h2);
    wr(A_FA, bitv(12));
    chk("R9 fast route", {30'd0, irq_out, fiq_out}, 32'h1);
    rd(A_FA, v); chk("R11 fast select readback", v, bitv(12));
  endtask

  task automatic t_cascade();
    logic [31:0] v;
    do_reset();
    line_in = '1;
    wait_n(4);
    rd(A_ST, v); chk("R8 general lines only", v, 32'h3FFF_FFFC);
    sub_irq = 2'b01;
    wait_n(3);
    rd(A_ST, v); chk("R8 sub irq 0 to line 0", v & 32'hC000_0003, 32'h0000_0001);
    sub_irq = 2'b10; sub_fiq = 2'b01;
    wait_n(3);
    rd(A_ST, v); chk("R8 sub irq 1 and sub fiq 0", v & 32'hC000_0003, 32'h4000_0002);
    sub_irq = 2'b00; sub_fiq = 2'b10;
    wait_n(3);
    rd(A_ST, v); chk("R8 sub fiq 1 to line 31", v & 32'hC000_0003, 32'h8000_0000);
  endtask

  task automatic t_mask_ack();
    logic [31:0] v;
    do_reset();
    wr(A_TY, bitv(8));
    line_in[8-2] = 1'b1;
    wait_n(1);
    line_in[8-2] = 1'b0;
    wait_n(4);
    wr(A_EN, bitv(8));
    chk("R12 pending edge raises irq", {31'd0, irq_out}, 32'h1);
    wr(A_EN, 32'h0);
    chk("R12 mask drops irq", {31'd0, irq_out}, 32'h0);
    wr(A_ST, bitv(8));
    rd(A_ST, v); chk("R12 ack clears status", v, 32'h0);
    wr(A_EN, bitv(8));
    chk("R12 re-enable stays quiet", {31'd0, irq_out}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge_rise();
    t_edge_fall();
    t_fast();
    t_cascade();
    t_mask_ack();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule